// File: doc/BRIEF.md
# Pipelined Signed Dot-Product Engine

This block computes the inner product of two signed integer vectors that arrive as one pair per clock. Each pair goes through a multiplier built as a chain of segment registers. Each product then enters an adder chain of the same depth. The last adder segment loops back to the adder's second input, so the chain works as a ring of partial sums. Product i is added to the value that product i-4 left behind. The sum therefore splits into four interleaved partials: terms 1,5,9,…; 2,6,10,…; 3,7,11,…; and 4,8,12,…. All segment registers start at zero, so a product that meets an empty ring slot is added to zero.

The final pair of a vector is marked with a last flag. Once that product has entered the ring, the ring holds every partial sum. On the next edge the block adds the partials into one result, presents it, and pulses its done output. On that same edge it empties the ring for the next vector. A following vector may start on the very next cycle. A synchronous clear empties the whole pipeline between vectors and drops any vector still in flight.

Top module: `dot_accum`

## Requirements
- R1: A pair presented with `in_valid` high on clock edge k and flagged `in_last` produces `done` high and the result on `sum` after edge k+5, with the default 4-segment multiplier and 4-segment adder.
- R2: While `rst_n` is low, `done` is 0 and `sum` is 0.
- R3: `sum` equals the exact signed sum of a[i]*b[i] over all valid pairs of the vector, for any length including 1, 2, 3, lengths that are not multiples of 4, and lengths that are.
- R4: The first pair of a new vector may be presented on the edge right after the previous last pair. Each vector's result is unaffected by its neighbours, including a run of length-1 vectors.
- R5: `done` is high for exactly one cycle per completed vector, and only five edges after a valid pair carrying `in_last`.
- R6: `clr` high on an edge empties all pipeline state. It ignores the pair presented on that edge and cancels every vector whose `done` would fall on or after that edge. `sum` keeps its last value.
- R7: `sum` changes only on an edge that raises `done`, and holds between results.
- R8: Cycles with `in_valid` low add nothing, so gaps inside a vector leave its result unchanged. `in_last` is ignored while `in_valid` is low.
- R9: Operands are W-bit two's complement (W=16 by default) and `sum` is 2W+10 bits, so 1000 extreme-valued terms are summed exactly.
- R10: Slots 1 to 3 of the partial-sum ring are zero in the cycle `done` is high, so no partial sum carries into the next vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| clr | input | 1 | Synchronous flush of all pipeline state |
| in_valid | input | 1 | Pair on `in_a`/`in_b` is taken this edge |
| in_last | input | 1 | Pair is the final one of its vector |
| in_a | input | W | Signed operand A |
| in_b | input | W | Signed operand B |
| sum | output | 2W+10 | Signed inner product of the latest finished vector |
| done | output | 1 | One-cycle strobe: `sum` was just updated |

## Verification
The collision that matters is the reduction of one vector at the same edge as the first product of the next vector enters the ring. On that edge the ring must drop its feedback and take the new product alone. The bench provokes this by sending vectors back to back, including runs of length-1 vectors in which every edge both reduces and restarts. A second collision is a clear that lands on the edge where a pending result would appear, which must cancel that result. A behavioural model keeps a running sum and a queue of timed expected results, and it is compared against `done` and `sum` on every cycle.

// File: rtl/dot_accum.sv
module dot_accum #(
  parameter int W   = 16,
  parameter int SEG = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  in_valid,
  input  logic                  in_last,
  input  logic signed [W-1:0]   in_a,
  input  logic signed [W-1:0]   in_b,
  output logic signed [2*W+9:0] sum,
  output logic                  done
);
  localparam int PW = 2 * W;
  localparam int AW = 2 * W + 10;

  logic signed [PW-1:0] mp   [SEG];
  logic        [SEG-1:0] ml;
  logic signed [AW-1:0] ring [SEG];
  logic                 fin;
  logic signed [AW-1:0] mext;
  logic signed [AW-1:0] total;

  assign mext = {{(AW-PW){mp[SEG-1][PW-1]}}, mp[SEG-1]};

  always_comb begin
    total = '0;
    for (int k = 0; k < SEG; k++) total = total + ring[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int k = 0; k < SEG; k++) begin
        mp[k]   <= '0;
        ring[k] <= '0;
      end
      ml   <= '0;
      fin  <= 1'b0;
      done <= 1'b0;
    end else begin
      mp[0] <= in_valid ? PW'(in_a * in_b) : '0;
      for (int k = 1; k < SEG; k++) mp[k] <= mp[k-1];
      ml <= {ml[SEG-2:0], in_valid & in_last};
      if (fin) begin
        ring[0] <= mext;
        for (int k = 1; k < SEG; k++) ring[k] <= '0;
      end else begin
        ring[0] <= mext + ring[SEG-1];
        for (int k = 1; k < SEG; k++) ring[k] <= ring[k-1];
      end
      fin  <= ml[SEG-1];
      done <= fin;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sum <= '0;
    else if (!clr && fin) sum <= total;
  end

  logic [SEG+1:0] lhist;
  always_ff @(posedge clk) begin
    if (!rst_n) lhist <= '0;
    else lhist <= {lhist[SEG:0], in_valid & in_last};
  end

  a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lhist[SEG+1]);

  a_r6_clear_kills_done: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !done);

  a_r7_sum_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(sum));

  for (genvar g = 1; g < SEG; g++) begin : g_ring_chk
    a_r10_ring_empty: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ring[g] == '0);
  end
endmodule

// File: tb/dot_accum_tb.sv
module dot_accum_tb;
  localparam int TCK = 10;
  localparam int W   = 16;
  localparam int LAT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic in_valid = 1'b0;
  logic in_last = 1'b0;
  logic signed [W-1:0] in_a = '0;
  logic signed [W-1:0] in_b = '0;
  logic signed [2*W+9:0] sum;
  logic done;

  dot_accum #(.W(W), .SEG(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_last(in_last),
    .in_a(in_a), .in_b(in_b), .sum(sum), .done(done)
  );

  always #(TCK/2) clk = ~clk;

  typedef struct { int t; longint s; } exp_t;
  exp_t q[$];
  int cyc = 0;
  longint acc = 0;
  longint last_sum = 0;
  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R2";
  bit finished = 0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (clr) begin
        acc = 0;
        for (int i = q.size() - 1; i >= 0; i--) if (q[i].t >= cyc) q.delete(i);
      end else if (in_valid) begin
        acc = acc + longint'(in_a) * longint'(in_b);
        if (in_last) begin
          q.push_back('{t: cyc + LAT, s: acc});
          acc = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      if (!rst_n) begin
        n_cmp++;
        if (done !== 1'b0 || sum !== '0) begin
          n_bad++;
          $display("FAIL R2 reset: done=%0b sum=%0d expected done=0 sum=0", done, sum);
        end
      end else begin
        bit ed;
        longint got;
        ed = (q.size() > 0 && q[0].t == cyc);
        if (ed) begin
          last_sum = q[0].s;
          void'(q.pop_front());
        end
        got = longint'(sum);
        n_cmp++;
        if (done !== ed || got != last_sum) begin
          n_bad++;
          $display("FAIL %s cycle %0d: done=%0b sum=%0d expected done=%0b sum=%0d",
                   tag, cyc, done, got, ed, last_sum);
        end
      end
    end
  end

  task automatic put(bit v, bit l, int a, int b, bit c);
    @(negedge clk);
    in_valid = v; in_last = l; in_a = W'(a); in_b = W'(b); clr = c;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) put(0, 0, 0, 0, 0);
  endtask

  task automatic vec(int len, int gap);
    for (int i = 0; i < len; i++) begin
      put(1, i == len - 1, $urandom_range(0, 65535) - 32768, $urandom_range(0, 65535) - 32768, 0);
      for (int g = 0; g < gap; g++) put(0, 0, 0, 0, 0);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(TCK * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    finish_run();
  end

  initial begin
    tag = "R2";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    tag = "R1";
    put(1, 1, 3, 7, 0);
    idle(8);
    tag = "R3";
    for (int len = 1; len <= 13; len++) begin
      vec(len, 0);
      idle(7);
    end
    tag = "R8";
    vec(9, 2);
    idle(2);
    put(0, 1, 100, 100, 0);
    vec(3, 1);
    put(0, 1, 5, 5, 0);
    idle(8);
    tag = "R4";
    vec(5, 0); vec(1, 0); vec(1, 0); vec(1, 0); vec(4, 0); vec(2, 0); vec(7, 0);
    for (int i = 0; i < 10; i++) vec(1, 0);
    idle(8);
    tag = "R5";
    vec(3, 0); vec(6, 0);
    idle(10);
    tag = "R6";
    vec(6, 0);
    put(1, 0, 999, 999, 1);
    vec(4, 0);
    idle(8);
    vec(4, 0);
    idle(4);
    put(0, 0, 0, 0, 1);
    vec(2, 0);
    idle(8);
    vec(3, 0);
    put(1, 1, 77, 77, 1);
    idle(8);
    tag = "R9";
    for (int i = 0; i < 1000; i++) put(1, i == 999, -32768, -32768, 0);
    idle(8);
    for (int i = 0; i < 1000; i++) put(1, i == 999, 32767, -32768, 0);
    idle(8);
    tag = "R7";
    idle(20);
    finish_run();
  end
endmodule